// File: doc/BRIEF.md
# I2C Target Receiver with 7-bit and 10-bit Addressing

This block is an I2C target (slave) receiver. A fast system clock samples the bus lines SCL and SDA through a small synchroniser and finds START and STOP conditions, clock edges and data bits. It compares the first byte of a transfer with a host-programmed address register. The comparison is either one 7-bit address or a two-step 10-bit address. A matched address byte is acknowledged by pulling SDA low for the ninth clock. Each matched address byte, and each data byte of a write, goes to a host-readable buffer.

The receiver is double buffered. A hidden shift register collects the next byte while the host still holds the previous one. If a byte completes while the buffer is unread, that byte is dropped and left unacknowledged, and a sticky overflow flag is set. In 10-bit mode the host first loads the high header pattern into the address register. When the header matches and is acknowledged, the host reloads the register with the low eight address bits before the second address byte ends. The host sees a status register that reports bus conditions, the kind of byte last stored, the direction, and whether the low address byte is due next.

Host access is a plain register port with four word addresses: 0 control, 1 status, 2 receive buffer, 3 address.

Top module: `i2c_tgt`

## Requirements
- R1: The block ignores the bus unless control bit 5 is 1 and the control mode field (bits 3:0) is 6 (7-bit target) or 7 (10-bit target). Code 8 (master) and every other code count as disabled. While disabled, SDA is never driven and status bits 3 and 4 stay 0.
- R2: SDA falling while SCL is high sets status bit 3 (START seen) and clears bit 4. SDA rising while SCL is high sets status bit 4 (STOP seen) and clears bit 3. The two bits are never both 1.
- R3: In mode 6, bits 7:1 of the first byte after a START are compared with address register bits 7:1. On a match the ninth clock sees SDA low, and bit 0 of that byte is latched into status bit 2 (1 = read).
- R4: An address byte that does not match gets no acknowledge, is not stored, and leaves the interrupt flag and buffer-full bit unchanged.
- R5: Every stored byte (a matched address byte, or any data byte after a matched write address) is copied to register 2. It sets status bit 0 (buffer full), control bit 7 and output irq_o, and sets status bit 5 to 1 for data or 0 for an address.
- R6: Reading register 2 clears status bit 0. Control bits 7 (interrupt) and 6 (overflow) stay set until the host writes 0 to them.
- R7: A byte that completes while status bit 0 is 1 is not acknowledged and leaves register 2 unchanged, and it sets control bit 6.
- R8: In mode 7 the first byte after a START must be 11110 A9 A8 0. Its bits 7:1 are compared with address register bits 7:1. On a match the byte is acknowledged and status bit 1 (low address byte due) is set.
- R9: In mode 7 the second address byte is compared in all 8 bits with the address register as reloaded by the host. A match is acknowledged, clears status bit 1, and admits data bytes. A mismatch gets no acknowledge and forgets the matched high byte.
- R10: After a repeated START, a read header 11110 A9 A8 1 is acknowledged, and sets status bit 2, only when a write header with the same A9 A8 has matched since the last STOP.
- R11: The acknowledge drive is released at the SCL falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| irq_o | output | 1 | Byte-received interrupt flag |
| reg_addr_i | input | 2 | Host register select |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe (side effect on register 2) |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for reg_addr_i |

## Verification
A change on SCL or SDA takes two synchroniser clocks and one edge-detect clock to reach the byte engine. So START/STOP status, the stored byte and the flags, and the acknowledge drive all settle three system clocks after the line change. The bench holds every bus level for twelve clocks and reads results only after that hold. The acknowledge is sampled while the ninth SCL pulse is high, and its release is sampled one hold after the ninth falling edge. Register reads are combinational, so the bench samples read data within the cycle that selects them, and the side effect of a buffer read lands at the next edge.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
    localparam int DW = 8;
    localparam int BW = $clog2(DW + 1);

    localparam logic [3:0] MODE_T7  = 4'h6;
    localparam logic [3:0] MODE_T10 = 4'h7;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_BUF  = 2'd2;
    localparam logic [1:0] RA_ADDR = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_LO,
        PH_DATA,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        phase_e          ph;
        logic [BW-1:0]   bits;
        logic [DW-1:0]   sh;
        logic            in_ack;
        logic            oe;
        logic            hi_ok;
        logic [1:0]      hi_bits;
        logic            rw;
        logic            ua;
    } eng_t;

    typedef struct packed {
        logic [3:0]      mode;
        logic            en;
        logic            ovf;
        logic            irq;
        logic            full;
        logic [DW-1:0]   rbuf;
        logic [DW-1:0]   addr;
        logic            s;
        logic            p;
        logic            da;
    } regs_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ch;
        logic [STAGES-1:0] sda_ch;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.scl_ch = {sy_q.scl_ch[STAGES-2:0], scl_i};
        sy_d.sda_ch = {sy_q.sda_ch[STAGES-2:0], sda_i};
        sy_d.scl_p  = sy_q.scl_ch[STAGES-1];
        sy_d.sda_p  = sy_q.sda_ch[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    assign scl_s    = sy_q.scl_ch[STAGES-1];
    assign sda_s    = sy_q.sda_ch[STAGES-1];
    assign scl_rise = scl_s & ~sy_q.scl_p;
    assign scl_fall = ~scl_s & sy_q.scl_p;
    assign start_ev = scl_s & sy_q.scl_p & sy_q.sda_p & ~sda_s;
    assign stop_ev  = scl_s & sy_q.scl_p & ~sy_q.sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
`timescale 1ns/1ps
module i2c_tgt_match
    import i2c_tgt_pkg::*;
(
    input  phase_e        ph,
    input  logic          ten_bit,
    input  logic [DW-1:0] byte_i,
    input  logic [DW-1:0] addr_i,
    input  logic          hi_ok,
    input  logic [1:0]    hi_bits,
    output logic          hit,
    output phase_e        nxt,
    output logic          set_hi,
    output logic          clr_hi,
    output logic          ua_set,
    output logic          ua_clr,
    output logic          rw_load
);
    logic hdr;
    logic upper_eq;

    assign hdr      = (byte_i[7:3] == 5'b11110);
    assign upper_eq = (byte_i[DW-1:1] == addr_i[DW-1:1]);

    always_comb begin
        hit     = 1'b0;
        nxt     = PH_HOLD;
        set_hi  = 1'b0;
        clr_hi  = 1'b0;
        ua_set  = 1'b0;
        ua_clr  = 1'b0;
        rw_load = 1'b0;
        if (ph == PH_ADDR) begin
            if (!ten_bit) begin
                hit = upper_eq;
                nxt = (hit && !byte_i[0]) ? PH_DATA : PH_HOLD;
            end else if (!byte_i[0]) begin
                hit    = hdr && upper_eq;
                set_hi = hit;
                clr_hi = !hit;
                ua_set = hit;
                nxt    = hit ? PH_ADDR_LO : PH_HOLD;
            end else begin
                hit = hdr && hi_ok && (byte_i[2:1] == hi_bits);
                nxt = PH_HOLD;
            end
            rw_load = hit;
        end else if (ph == PH_ADDR_LO) begin
            hit    = (byte_i == addr_i);
            clr_hi = !hit;
            ua_clr = 1'b1;
            nxt    = hit ? PH_DATA : PH_HOLD;
        end
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          ten_bit,
    input  logic [DW-1:0] addr_i,
    input  logic          buf_full,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    output logic          push,
    output logic          push_data,
    output logic [DW-1:0] push_byte,
    output logic          rw_o,
    output logic          ua_o,
    output logic          sda_oe_o
);
    localparam logic [BW-1:0] FULL_CNT = BW'(DW);
    localparam eng_t ENG_RST = '{ph: PH_IDLE, default: '0};

    eng_t   en_d, en_q;
    logic   counting;
    logic   m_hit, m_set_hi, m_clr_hi, m_ua_set, m_ua_clr, m_rw_load;
    phase_e m_nxt;

    i2c_tgt_match match_i (
        .ph      (en_q.ph),
        .ten_bit (ten_bit),
        .byte_i  (en_q.sh),
        .addr_i  (addr_i),
        .hi_ok   (en_q.hi_ok),
        .hi_bits (en_q.hi_bits),
        .hit     (m_hit),
        .nxt     (m_nxt),
        .set_hi  (m_set_hi),
        .clr_hi  (m_clr_hi),
        .ua_set  (m_ua_set),
        .ua_clr  (m_ua_clr),
        .rw_load (m_rw_load)
    );

    assign counting = (en_q.ph == PH_ADDR) || (en_q.ph == PH_ADDR_LO) ||
                      (en_q.ph == PH_DATA);

    always_comb begin
        en_d      = en_q;
        push      = 1'b0;
        push_data = 1'b0;
        if (!active) begin
            en_d = ENG_RST;
        end else if (start_ev) begin
            en_d.ph     = PH_ADDR;
            en_d.bits   = '0;
            en_d.in_ack = 1'b0;
            en_d.oe     = 1'b0;
        end else if (stop_ev) begin
            en_d.ph     = PH_IDLE;
            en_d.bits   = '0;
            en_d.in_ack = 1'b0;
            en_d.oe     = 1'b0;
            en_d.hi_ok  = 1'b0;
            en_d.ua     = 1'b0;
        end else if (scl_rise && counting && !en_q.in_ack && en_q.bits < FULL_CNT) begin
            en_d.sh   = {en_q.sh[DW-2:0], sda_s};
            en_d.bits = en_q.bits + 1'b1;
        end else if (scl_fall) begin
            if (en_q.in_ack) begin
                en_d.in_ack = 1'b0;
                en_d.oe     = 1'b0;
                en_d.bits   = '0;
            end else if (counting && en_q.bits == FULL_CNT) begin
                en_d.in_ack = 1'b1;
                if (en_q.ph == PH_DATA) begin
                    push      = 1'b1;
                    push_data = 1'b1;
                    en_d.oe   = !buf_full;
                end else begin
                    push    = m_hit;
                    en_d.oe = m_hit && !buf_full;
                    en_d.ph = m_nxt;
                    if (m_set_hi) begin
                        en_d.hi_ok   = 1'b1;
                        en_d.hi_bits = en_q.sh[2:1];
                    end
                    if (m_clr_hi)  en_d.hi_ok = 1'b0;
                    if (m_ua_set)  en_d.ua    = 1'b1;
                    if (m_ua_clr)  en_d.ua    = 1'b0;
                    if (m_rw_load) en_d.rw    = en_q.sh[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= ENG_RST;
        else        en_q <= en_d;
    end

    assign push_byte = en_q.sh;
    assign rw_o      = en_q.rw;
    assign ua_o      = en_q.ua;
    assign sda_oe_o  = en_q.oe;
endmodule

// File: rtl/i2c_tgt.sv
`timescale 1ns/1ps
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    output logic          irq_o,
    input  logic [1:0]    reg_addr_i,
    input  logic          reg_wr_i,
    input  logic          reg_rd_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o
);
    regs_t         st_d, st_q;
    logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic          active, ten_bit;
    logic          push, push_data, eng_rw, eng_ua;
    logic [DW-1:0] push_byte;
    logic          ctrl_wr, addr_wr, buf_rd;
    logic          unused_wbit;

    assign unused_wbit = reg_wdata_i[4];

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    assign ten_bit = (st_q.mode == MODE_T10);
    assign active  = st_q.en && ((st_q.mode == MODE_T7) || ten_bit);

    i2c_tgt_engine eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .ten_bit   (ten_bit),
        .addr_i    (st_q.addr),
        .buf_full  (st_q.full),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .push      (push),
        .push_data (push_data),
        .push_byte (push_byte),
        .rw_o      (eng_rw),
        .ua_o      (eng_ua),
        .sda_oe_o  (sda_oe_o)
    );

    assign ctrl_wr = reg_wr_i && (reg_addr_i == RA_CTRL);
    assign addr_wr = reg_wr_i && (reg_addr_i == RA_ADDR);
    assign buf_rd  = reg_rd_i && (reg_addr_i == RA_BUF);

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.mode = reg_wdata_i[3:0];
            st_d.en   = reg_wdata_i[5];
            st_d.ovf  = st_q.ovf & reg_wdata_i[6];
            st_d.irq  = st_q.irq & reg_wdata_i[7];
        end
        if (addr_wr) st_d.addr = reg_wdata_i;
        if (buf_rd)  st_d.full = 1'b0;
        if (!active) begin
            st_d.s = 1'b0;
            st_d.p = 1'b0;
        end else if (start_ev) begin
            st_d.s = 1'b1;
            st_d.p = 1'b0;
        end else if (stop_ev) begin
            st_d.s = 1'b0;
            st_d.p = 1'b1;
        end
        if (push) begin
            if (st_q.full) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.rbuf = push_byte;
                st_d.full = 1'b1;
                st_d.irq  = 1'b1;
                st_d.da   = push_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr_i)
            RA_CTRL: reg_rdata_o = {st_q.irq, st_q.ovf, st_q.en, 1'b0, st_q.mode};
            RA_STAT: reg_rdata_o = {2'b00, st_q.da, st_q.p, st_q.s, eng_rw, eng_ua, st_q.full};
            RA_BUF:  reg_rdata_o = st_q.rbuf;
            default: reg_rdata_o = st_q.addr;
        endcase
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/i2c_tgt_chk.sv
`timescale 1ns/1ps
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          ovf,
    input logic          irq,
    input logic          full,
    input logic [DW-1:0] rbuf,
    input logic          s,
    input logic          p,
    input logic          ctrl_wr,
    input logic          buf_rd
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sda_oe); // R1
    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s && p)); // R2
    AST_FULL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> irq); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ctrl_wr |=> irq); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !ctrl_wr |=> ovf); // R6
    AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        full && !buf_rd |=> $stable(rbuf)); // R7
    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R11
endmodule

bind i2c_tgt i2c_tgt_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .sda_oe  (sda_oe_o),
    .scl_s   (scl_s),
    .ovf     (st_q.ovf),
    .irq     (st_q.irq),
    .full    (st_q.full),
    .rbuf    (st_q.rbuf),
    .s       (st_q.s),
    .p       (st_q.p),
    .ctrl_wr (ctrl_wr),
    .buf_rd  (buf_rd)
);

// File: tb/i2c_tgt_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, irq;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;

    // behavioural model of the host-visible state
    bit       m_s, m_p, m_rw, m_ua, m_da, m_full, m_irq, m_ovf;
    bit [7:0] m_buf, m_base;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_tgt dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .irq_o(irq), .reg_addr_i(reg_addr),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata)
    );

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic hold;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input [1:0] a, input [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input [1:0] a, output [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic bus_start;
        if (!scl_m) begin sda_m = 1'b1; hold(); scl_m = 1'b1; hold(); end
        sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
        m_s = 1'b1; m_p = 1'b0;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
        m_p = 1'b1; m_s = 1'b0; m_ua = 1'b0;
    endtask

    task automatic xfer(input [7:0] b, input bit exp_ack, input string r);
        bit ack;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold();
        end
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        ack = !sda_line;
        chk(r, ack, exp_ack);
        scl_m = 1'b0; hold();
        chk("R11", sda_oe, 0);
    endtask

    task automatic store(input [7:0] b, input bit d);
        if (m_full) m_ovf = 1'b1;
        else begin m_buf = b; m_full = 1'b1; m_irq = 1'b1; m_da = d; end
    endtask

    task automatic chk_stat(input string r);
        bit [7:0] v;
        rd(2'd1, v);
        chk(r, v, {2'b00, m_da, m_p, m_s, m_rw, m_ua, m_full});
    endtask

    task automatic chk_ctrl(input string r);
        bit [7:0] v;
        rd(2'd0, v);
        chk(r, v, {m_irq, m_ovf, m_base[5:0]});
    endtask

    task automatic host_buf(input string r);
        bit [7:0] v;
        rd(2'd2, v);
        chk(r, v, m_buf);
        m_full = 1'b0;
    endtask

    task automatic set_ctrl(input [7:0] d);
        m_base = d;
        wr(2'd0, d);
    endtask

    task automatic clr_flags;
        wr(2'd0, m_base);
        m_irq = 1'b0; m_ovf = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1: disabled after reset)
        rd(2'd0, v); chk("R1 reset ctrl", v, 0);
        chk_stat("R1 reset stat");
        chk("R1 reset irq", irq, 0);
        chk("R1 reset sda_oe", sda_oe, 0);

        // R1: enable clear, then master code
        wr(2'd3, 8'h84);
        set_ctrl(8'h06);
        bus_start(); m_s = 0;
        xfer(8'h84, 0, "R1 disabled ack"); bus_stop(); m_p = 0;
        chk_stat("R1 disabled stat");
        set_ctrl(8'h28);
        bus_start(); m_s = 0;
        xfer(8'h84, 0, "R1 master code ack"); bus_stop(); m_p = 0;
        chk_stat("R1 master code stat");
        chk("R1 irq", irq, 0);

        // 7-bit target
        set_ctrl(8'h26);
        bus_start();
        chk_stat("R2 start seen");
        xfer(8'h84, 1, "R3 address ack"); m_rw = 0; store(8'h84, 0);
        chk_stat("R5 address stored");
        chk("R5 irq_o", irq, 1);
        host_buf("R5 address byte");
        chk_stat("R6 full cleared");
        chk_ctrl("R6 irq held");
        clr_flags(); chk_ctrl("R6 irq cleared");
        xfer(8'h3C, 1, "R5 data ack"); store(8'h3C, 1);
        chk_stat("R5 data stat");
        host_buf("R5 data byte");
        xfer(8'h5A, 1, "R5 data ack 2"); store(8'h5A, 1);
        xfer(8'hC3, 0, "R7 overflow nack"); store(8'hC3, 1);
        chk_ctrl("R7 overflow flag");
        host_buf("R7 buffer kept");
        xfer(8'h11, 1, "R6 ack after overflow"); store(8'h11, 1);
        chk_ctrl("R6 overflow sticky");
        host_buf("R6 next byte");
        clr_flags(); chk_ctrl("R6 flags cleared");
        bus_stop();
        chk_stat("R2 stop seen");

        bus_start();
        xfer(8'h86, 0, "R4 mismatch nack");
        chk_stat("R4 nothing stored");
        chk("R4 irq unchanged", irq, 0);
        bus_stop();
        bus_start();
        xfer(8'h85, 1, "R3 read address ack"); m_rw = 1; store(8'h85, 0);
        chk_stat("R3 read direction");
        host_buf("R3 read address byte");
        clr_flags(); bus_stop();

        // 10-bit target: A9A8 = 01, low byte 5A
        wr(2'd3, 8'hF2);
        set_ctrl(8'h27);
        bus_start();
        xfer(8'hF2, 1, "R8 high header ack"); m_rw = 0; m_ua = 1; store(8'hF2, 0);
        chk_stat("R8 low byte due");
        host_buf("R8 header byte");
        wr(2'd3, 8'h5A);
        xfer(8'h5A, 1, "R9 low byte ack"); m_ua = 0; store(8'h5A, 0);
        chk_stat("R9 low byte done");
        host_buf("R9 low byte");
        xfer(8'h77, 1, "R9 data ack"); store(8'h77, 1);
        host_buf("R9 data byte");
        bus_start();
        xfer(8'hF3, 1, "R10 read header ack"); m_rw = 1; store(8'hF3, 0);
        chk_stat("R10 read direction");
        host_buf("R10 read header byte");
        clr_flags(); bus_stop();

        wr(2'd3, 8'hF2);
        bus_start();
        xfer(8'hF2, 1, "R8 header ack 2"); m_rw = 0; m_ua = 1; store(8'hF2, 0);
        host_buf("R8 header byte 2");
        wr(2'd3, 8'h5A);
        xfer(8'h5B, 0, "R9 low mismatch nack"); m_ua = 0;
        chk_stat("R9 low mismatch stat");
        bus_start();
        xfer(8'hF3, 0, "R10 read after low mismatch");
        bus_stop();
        clr_flags();
        bus_start();
        xfer(8'hF3, 0, "R10 read without header");
        bus_stop();
        chk_stat("R10 final stat");
        chk("R10 irq", irq, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule